// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a register of `WIDTH` bits. A two-bit mode input picks one of four operations on every rising clock edge: keep the contents, shift toward the high end, shift toward the low end, or load all bits at once. Stage 0 is the first stage and stage `WIDTH-1` is the last.

Each shift direction has its own serial input. Both end bits are brought out as separate ports, so several instances can be chained into a wider register. Each instance's end bit is wired to the serial input of its neighbour on that side.

The parallel data path is a single bidirectional three-state bus. During a load, the bus carries data into the register. When the output enable is high and the block is not loading, the register drives its contents onto the same lines. An asynchronous active-low clear empties the register whatever the mode.

The mode is handled as a four-state enumeration: `MODE_HOLD`, `MODE_SHR`, `MODE_SHL` and `MODE_LOAD`. Any mode may follow any other on the next edge. The transition taken at each edge is the one selected by the mode input.

Top module: `univ_shift_reg`

## Requirements
- R1: While `clr_n` is 0, every bit of `q_o` is 0 immediately, with no clock edge needed, whatever the mode.
- R2: With mode 2'b00 (hold), `q_o` keeps its value across a rising edge.
- R3: With mode 2'b01 (shift right), a rising edge moves bit i-1 into bit i for i = 1..WIDTH-1, and `ser_right_i` enters bit 0.
- R4: With mode 2'b10 (shift left), a rising edge moves bit i+1 into bit i for i = 0..WIDTH-2, and `ser_left_i` enters bit WIDTH-1.
- R5: With mode 2'b11 (parallel load), a rising edge copies the value on `data_io` into `q_o`, with bit i taken from line i.
- R6: `data_io` carries `q_o` when `oe_i` is 1 and the mode is not 2'b11; otherwise the block leaves all lines at high-impedance.
- R7: `first_o` always equals bit 0 and `last_o` always equals bit WIDTH-1 of the contents, for chaining instances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_right_i | input | 1 | Serial bit entering stage 0 on a right shift |
| ser_left_i | input | 1 | Serial bit entering stage WIDTH-1 on a left shift |
| oe_i | input | 1 | Enables driving of the contents onto the data bus |
| data_io | inout | WIDTH | Shared parallel load / readout bus |
| q_o | output | WIDTH | Register contents |
| first_o | output | 1 | Stage 0 bit, for chaining |
| last_o | output | 1 | Stage WIDTH-1 bit, for chaining |

## Verification
Hold, shift and load results are due one clock edge after the mode and serial or bus inputs are applied. The bus drive and the end bits follow the register and the mode with no edge in between. The clear acts at once, without waiting for an edge. The bench drives inputs on the falling edge and advances its reference model at the following rising edge. It compares contents, end bits and the bus level on the next falling edge. For the clear, it pulls `clr_n` low between edges and compares one nanosecond later, before any clock edge can occur.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;
endpackage

// File: rtl/usr_cell.sv
module usr_cell
    import usr_pkg::*;
(
    input  logic  clk,
    input  logic  clr_n,
    input  mode_e mode_i,
    input  logic  lower_i,
    input  logic  upper_i,
    input  logic  par_i,
    output logic  q_o
);
    logic nxt;

    // four-way next-state selection for one stage
    always_comb begin
        unique case (mode_i)
            MODE_HOLD: nxt = q_o;
            MODE_SHR:  nxt = lower_i;
            MODE_SHL:  nxt = upper_i;
            MODE_LOAD: nxt = par_i;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_o <= 1'b0;
        else        q_o <= nxt;
    end
endmodule

// File: rtl/usr_bus_drv.sv
module usr_bus_drv
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             oe_i,
    input  mode_e            mode_i,
    input  logic [WIDTH-1:0] val_i,
    inout  wire  [WIDTH-1:0] bus_io
);
    logic drive_en;

    always_comb drive_en = oe_i && (mode_i != MODE_LOAD);

    assign bus_io = drive_en ? val_i : {WIDTH{1'bz}};

    assert_drive_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (oe_i && mode_i != MODE_LOAD) |-> (bus_io === val_i));
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode_i,
    input  logic             ser_right_i,
    input  logic             ser_left_i,
    input  logic             oe_i,
    inout  wire  [WIDTH-1:0] data_io,
    output logic [WIDTH-1:0] q_o,
    output logic             first_o,
    output logic             last_o
);
    localparam int TOP = WIDTH - 1;

    mode_e mode;
    logic [WIDTH-1:0] stage_q;

    always_comb mode = mode_e'(mode_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic lower_n, upper_n;
        if (i == 0) begin : g_lo_end
            always_comb lower_n = ser_right_i;
        end else begin : g_lo_mid
            always_comb lower_n = stage_q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            always_comb upper_n = ser_left_i;
        end else begin : g_hi_mid
            always_comb upper_n = stage_q[i+1];
        end
        usr_cell u_cell (
            .clk     (clk),
            .clr_n   (clr_n),
            .mode_i  (mode),
            .lower_i (lower_n),
            .upper_i (upper_n),
            .par_i   (data_io[i]),
            .q_o     (stage_q[i])
        );
    end

    usr_bus_drv #(.WIDTH(WIDTH)) u_drv (
        .clk    (clk),
        .clr_n  (clr_n),
        .oe_i   (oe_i),
        .mode_i (mode),
        .val_i  (stage_q),
        .bus_io (data_io)
    );

    always_comb begin
        q_o     = stage_q;
        first_o = stage_q[0];
        last_o  = stage_q[TOP];
    end

    assert_clear_R1: assert property (@(posedge clk)
        !clr_n |-> (q_o == '0));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_HOLD) |=> $stable(q_o));
    assert_shr_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_SHR) |=> (q_o == {$past(q_o[TOP-1:0]), $past(ser_right_i)}));
    assert_shl_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_SHL) |=> (q_o == {$past(ser_left_i), $past(q_o[TOP:1])}));
    assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_LOAD) |=> (q_o == $past(data_io)));
endmodule

// File: tb/sim_univ_shift_reg.sv
`timescale 1ns/1ps
module sim_univ_shift_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         sr = 1'b0, sl = 1'b0, oe = 1'b0;
    logic [W-1:0] tb_drv = '0;
    logic         tb_en = 1'b0;
    wire  [W-1:0] bus;
    logic [W-1:0] q;
    logic         first, last;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] model = '0;

    assign bus = tb_en ? tb_drv : {W{1'bz}};

    always #2.5 clk = ~clk;

    univ_shift_reg #(.WIDTH(W)) u0 (
        .clk(clk), .clr_n(clr_n), .mode_i(mode), .ser_right_i(sr),
        .ser_left_i(sl), .oe_i(oe), .data_io(bus), .q_o(q),
        .first_o(first), .last_o(last)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2-R5 contents", q, model);
        chk("R7 first", {{(W-1){1'b0}}, first}, {{(W-1){1'b0}}, model[0]});
        chk("R7 last", {{(W-1){1'b0}}, last}, {{(W-1){1'b0}}, model[W-1]});
        if (oe && mode != 2'b11) chk("R6 bus driven", bus, model);
        else if (!tb_en)         chk("R6 bus released", bus, {W{1'bz}});
    endtask

    // apply inputs at the falling edge, advance model at the rising edge
    task automatic step(input logic [1:0] m, input logic r, input logic l,
                        input logic o, input logic [W-1:0] d);
        mode = m; sr = r; sl = l; oe = o;
        tb_en = (m == 2'b11); tb_drv = d;
        #0.5 check_all();
        @(posedge clk);
        case (m)
            2'b01: model = (model << 1) | W'(r);
            2'b10: model = (model >> 1) | (W'(l) << (W-1));
            2'b11: model = d;
            default: ;
        endcase
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", q, '0);
        clr_n = 1'b1;
        @(negedge clk);
        // R5 load, R6 bus released while loading
        step(2'b11, 0, 0, 1, 8'hA5);
        // R2 hold with bus driven (R6)
        step(2'b00, 1, 1, 1, '0);
        // R3 shift right pattern
        step(2'b01, 1, 0, 0, '0);
        step(2'b01, 0, 0, 1, '0);
        step(2'b01, 1, 0, 1, '0);
        // R4 shift left pattern, with last-stage entry
        step(2'b10, 0, 1, 0, '0);
        step(2'b10, 0, 0, 1, '0);
        step(2'b10, 1, 1, 1, '0);
        // R4 walking a one out through the first stage, R7 ends
        step(2'b11, 0, 0, 0, 8'h01);
        step(2'b10, 0, 0, 1, '0);
        step(2'b11, 0, 0, 0, 8'h80);
        step(2'b01, 0, 0, 1, '0);
        // mixed sequence
        for (int i = 0; i < 300; i++)
            step(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
        // R1 asynchronous clear between edges, during a shift
        step(2'b11, 0, 0, 0, 8'hFF);
        mode = 2'b01; sr = 1'b1; tb_en = 1'b0;
        #1 clr_n = 1'b0;
        #1 chk("R1 async clear", q, '0);
        model = '0;
        @(posedge clk); @(negedge clk);
        chk("R1 clear overrides mode", q, '0);
        clr_n = 1'b1;
        step(2'b01, 1, 0, 1, '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule